// File: doc/BRIEF.md
# BCD Time-of-Day Register Bank

This block keeps a calendar clock in packed BCD: seconds, minutes, hours, weekday, day of month, month and a two-digit year. It is driven by a single-cycle tick that pulses once per second. An external prescaler makes that tick. The clock fields are reachable through a byte-wide register port. The port decodes the eight highest byte addresses of an 8 KB space. The rest of that space, with alarm matching and watchdog logic, belongs to neighbouring blocks.

Every field write is range-checked before it is stored. Each field has its own mask and legal range, and an illegal value leaves the field untouched. The top bit of the seconds register is a halt flag that freezes counting and reads back. The control register forces three of its bits on every write. Reads are combinational. Writes land on the next clock edge.

Top module: `tod_bcd_bank`

## Requirements
- R1: After reset the bank reads control 0x90, seconds 0x00, minutes 0x00, hours 0x00, weekday register 0x00, date 0x01, month 0x01 and year 0x00.
- R2: Seconds (offset 1) and minutes (offset 2) take the low 7 bits of the written byte as BCD. A value is accepted only when both digits are 0-9 and the value is 00-59; any other value is ignored.
- R3: Hours (offset 3) take the low 6 bits and accept 00-23. Date (offset 5) takes the low 6 bits and accepts 01-31. Month (offset 6) takes the low 5 bits and accepts 01-12. Year (offset 7) takes all 8 bits and accepts 00-99. Values with a digit above 9 are ignored, and so is anything out of range.
- R4: Bit 7 of seconds is a halt flag. It is stored on every seconds write, whether or not the BCD value is legal, and it reads back in bit 7. While it is set, ticks change no field. Once it is cleared, counting continues from the held value.
- R5: A control write (offset 0) stores the written byte with bit 5 cleared and bits 7 and 4 set.
- R6: A weekday-register write (offset 4) stores bits 2:0 as the weekday and bit 6 as a century flag. A read returns the century flag in bit 6 and the weekday in bits 2:0, with the other bits zero.
- R7: Offset 0x1FF1 and every address outside 0x1FF8-0x1FFF read 0x00, and writes to them change no clock register.
- R8: Each tick while running advances seconds. 59 wraps to 00 and carries into minutes, minutes carry into hours, and hours 23 wraps to 00 and carries into date and weekday. Weekday counts 0-6 and a carry from 6 or 7 gives 0.
- R9: Date wraps to 01 after the last day of the current month. That day is 30 for April, June, September and November, 31 for the other months, and 28 for February, or 29 when the BCD year is a multiple of 4.
- R10: A date wrap advances month, 12 wraps to 01 and carries into year, and year 99 wraps to 00.
- R11: Register reads are combinational from the address, and a write takes effect at the next clock edge. When a write and a tick hit the same field in one cycle, the written value is stored. A carry out of that field is still taken from its value before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| addr_i | input | 13 | Byte address within the 8 KB map |
| wr_en_i | input | 1 | Write strobe for wdata_i at addr_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |

## Verification
The assertions assume tick_i is a clean single-cycle pulse and that every field holds legal BCD after reset, which only range-checked writes can change. The stimulus keeps to that. It changes inputs on the falling edge, never writes a date beyond the current month's length before a carry, and sets the clock fields before each rollover scenario. The write-versus-tick case is driven on purpose with both strobes in one cycle, so the assertions on write priority and carry-from-old-value are exercised.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DATE = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;

  localparam logic [3:0] OFF_CTRL = 4'd0;
  localparam logic [3:0] OFF_WDAY = 4'd4;

  // packed per-field tables, field 0 in the low slice
  localparam logic [NUM_FIELDS*8-1:0] FIELD_MIN  = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  localparam logic [NUM_FIELDS*8-1:0] FIELD_MAX  = {8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59};
  localparam logic [NUM_FIELDS*8-1:0] FIELD_MASK = {8'hFF, 8'h1F, 8'h3F, 8'h3F, 8'h7F, 8'h7F};
  localparam logic [NUM_FIELDS*3-1:0] FIELD_OFF  = {3'd7, 3'd6, 3'd5, 3'd3, 3'd2, 3'd1};

  function automatic logic bcd_ok(input logic [7:0] v, input logic [7:0] lo, input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic bcd_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction
endpackage

// File: rtl/tod_bcd_ctr.sv
module tod_bcd_ctr #(
  parameter int         W       = 8,
  parameter logic [7:0] RST_VAL = 8'h00,
  parameter logic [7:0] MIN_VAL = 8'h00
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] max_i,
  output logic [W-1:0] q_o,
  output logic         carry_o
);
  logic [W-1:0] q_q;
  logic         at_top;

  assign at_top  = (q_q >= max_i);
  assign carry_o = inc_i & at_top;
  assign q_o     = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= W'(RST_VAL);
    else if (wr_i)   q_q <= wdata_i;
    else if (inc_i)  q_q <= at_top ? W'(MIN_VAL) : W'(tod_pkg::bcd_inc(8'(q_q)));
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !wr_i |=> $stable(q_o));                                   // R8
  AST_WRAP_TO_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !wr_i && (q_o >= max_i) |=> q_o == W'(MIN_VAL));            // R9
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> q_o == $past(wdata_i));                                     // R11
endmodule

// File: rtl/tod_month_len.sv
module tod_month_len (
  input  logic [7:0] month_i,
  input  logic [7:0] year_i,
  output logic [7:0] last_day_o
);
  always_comb begin
    unique case (month_i)
      8'h02:                       last_day_o = tod_pkg::bcd_leap(year_i) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11:  last_day_o = 8'h30;
      default:                     last_day_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/tod_wr_decode.sv
module tod_wr_decode
  import tod_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [7:0]          wdata_i,
  output logic [NUM_FIELDS-1:0] fld_we_o,
  output logic [NUM_FIELDS*8-1:0] fld_val_o,
  output logic                ctrl_we_o,
  output logic [7:0]          ctrl_val_o,
  output logic                halt_we_o,
  output logic                wday_we_o
);
  logic       bank_hit;
  logic [2:0] off;

  assign bank_hit = wr_en_i && (addr_i[ADDR_W-1:3] == '1);
  assign off      = addr_i[2:0];

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    logic [7:0] masked;
    assign masked = wdata_i & FIELD_MASK[i*8 +: 8];
    assign fld_val_o[i*8 +: 8] = masked;
    assign fld_we_o[i] = bank_hit && (off == FIELD_OFF[i*3 +: 3]) &&
                         bcd_ok(masked, FIELD_MIN[i*8 +: 8], FIELD_MAX[i*8 +: 8]);
  end

  assign ctrl_we_o  = bank_hit && (off == OFF_CTRL[2:0]);
  assign ctrl_val_o = (wdata_i & 8'hDF) | 8'h90;
  assign halt_we_o  = bank_hit && (off == FIELD_OFF[F_SEC*3 +: 3]);
  assign wday_we_o  = bank_hit && (off == OFF_WDAY[2:0]);
endmodule

// File: rtl/tod_bcd_bank.sv
module tod_bcd_bank
  import tod_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam logic [ADDR_W-1:0] BANK_BASE = ADDR_W'((1 << ADDR_W) - 8);
  localparam logic [ADDR_W-1:0] SEC_ADDR  = BANK_BASE + ADDR_W'(1);

  logic [NUM_FIELDS-1:0]   fld_we, fld_inc, fld_carry;
  logic [NUM_FIELDS*8-1:0] fld_val, fld_q, fld_max;
  logic                    ctrl_we, halt_we, wday_we;
  logic [7:0]              ctrl_val, ctrl_q, last_day;
  logic                    halt_q, cent_q;
  logic [2:0]              wday_q;
  logic                    run_tick;

  tod_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wdata_i    (wdata_i),
    .fld_we_o   (fld_we),
    .fld_val_o  (fld_val),
    .ctrl_we_o  (ctrl_we),
    .ctrl_val_o (ctrl_val),
    .halt_we_o  (halt_we),
    .wday_we_o  (wday_we)
  );

  tod_month_len u_mlen (
    .month_i    (fld_q[F_MON*8 +: 8]),
    .year_i     (fld_q[F_YEAR*8 +: 8]),
    .last_day_o (last_day)
  );

  assign run_tick = tick_i && !halt_q;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_ctr
    if (i == 0) begin : g_first
      assign fld_inc[i] = run_tick;
    end else begin : g_chain
      assign fld_inc[i] = fld_carry[i-1];
    end
    if (i == F_DATE) begin : g_dyn
      assign fld_max[i*8 +: 8] = last_day;
    end else begin : g_fix
      assign fld_max[i*8 +: 8] = FIELD_MAX[i*8 +: 8];
    end
    tod_bcd_ctr #(
      .W       (8),
      .RST_VAL (FIELD_MIN[i*8 +: 8]),
      .MIN_VAL (FIELD_MIN[i*8 +: 8])
    ) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (fld_inc[i]),
      .wr_i    (fld_we[i]),
      .wdata_i (fld_val[i*8 +: 8]),
      .max_i   (fld_max[i*8 +: 8]),
      .q_o     (fld_q[i*8 +: 8]),
      .carry_o (fld_carry[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 8'h90;
      halt_q <= 1'b0;
      wday_q <= 3'd0;
      cent_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_val;
      if (halt_we) halt_q <= wdata_i[7];
      if (wday_we) begin
        wday_q <= wdata_i[2:0];
        cent_q <= wdata_i[6];
      end else if (fld_carry[F_HOUR]) begin
        wday_q <= (wday_q >= 3'd6) ? 3'd0 : wday_q + 3'd1;
      end
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i[ADDR_W-1:3] == '1) begin
      unique case (addr_i[2:0])
        3'd0: rdata_o = ctrl_q;
        3'd1: rdata_o = {halt_q, fld_q[F_SEC*8 +: 7]};
        3'd2: rdata_o = fld_q[F_MIN*8 +: 8];
        3'd3: rdata_o = fld_q[F_HOUR*8 +: 8];
        3'd4: rdata_o = {1'b0, cent_q, 3'b000, wday_q};
        3'd5: rdata_o = fld_q[F_DATE*8 +: 8];
        3'd6: rdata_o = fld_q[F_MON*8 +: 8];
        default: rdata_o = fld_q[F_YEAR*8 +: 8];
      endcase
    end
  end

  AST_CTRL_FIXED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]);                               // R5
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q && !wr_en_i |=> $stable(fld_q));                              // R4
  AST_HALT_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == SEC_ADDR |=> halt_q == $past(wdata_i[7]));      // R4
  AST_SEC_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == SEC_ADDR && !tick_i &&
    !bcd_ok(wdata_i & 8'h7F, 8'h00, 8'h59) |=> $stable(fld_q[F_SEC*8 +: 8])); // R2
  AST_DATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fld_q[F_DATE*8 +: 8] != 8'h00 && fld_q[F_DATE*8 +: 8] <= 8'h31);     // R9
  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == BANK_BASE - ADDR_W'(7) |-> rdata_o == 8'h00);              // R7
endmodule

// File: tb/tod_bcd_bank_tb.sv
module tod_bcd_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [12:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  int checks = 0;
  int errors = 0;

  localparam logic [12:0] A_CTRL = 13'h1FF8, A_SEC = 13'h1FF9, A_MIN = 13'h1FFA,
                          A_HOUR = 13'h1FFB, A_WDAY = 13'h1FFC, A_DATE = 13'h1FFD,
                          A_MON = 13'h1FFE, A_YEAR = 13'h1FFF, A_GAP = 13'h1FF1;

  always #2.5 clk = ~clk;

  tod_bcd_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); addr = a; #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rdata, exp);
    end
  endtask

  task automatic set_all(input logic [7:0] y, mo, d, h, mi, s);
    wr(A_YEAR, y); wr(A_MON, mo); wr(A_DATE, d);
    wr(A_HOUR, h); wr(A_MIN, mi); wr(A_SEC, s);
  endtask

  task automatic t_reset;
    rd(A_CTRL, 8'h90, "R1"); rd(A_SEC, 8'h00, "R1"); rd(A_MIN, 8'h00, "R1");
    rd(A_HOUR, 8'h00, "R1"); rd(A_WDAY, 8'h00, "R1"); rd(A_DATE, 8'h01, "R1");
    rd(A_MON, 8'h01, "R1"); rd(A_YEAR, 8'h00, "R1");
  endtask

  task automatic t_sec_min_range;
    wr(A_SEC, 8'h45); rd(A_SEC, 8'h45, "R2 accept");
    wr(A_SEC, 8'h60); rd(A_SEC, 8'h45, "R2 reject 60");
    wr(A_SEC, 8'h3A); rd(A_SEC, 8'h45, "R2 reject digit");
    wr(A_MIN, 8'h59); rd(A_MIN, 8'h59, "R2 accept");
    wr(A_MIN, 8'h7F); rd(A_MIN, 8'h59, "R2 reject");
  endtask

  task automatic t_other_range;
    wr(A_HOUR, 8'hA3); rd(A_HOUR, 8'h23, "R3 hour mask");
    wr(A_HOUR, 8'h24); rd(A_HOUR, 8'h23, "R3 hour reject");
    wr(A_DATE, 8'h31); rd(A_DATE, 8'h31, "R3 date accept");
    wr(A_DATE, 8'h00); rd(A_DATE, 8'h31, "R3 date zero");
    wr(A_MON, 8'h12); rd(A_MON, 8'h12, "R3 month accept");
    wr(A_MON, 8'h13); rd(A_MON, 8'h12, "R3 month reject");
    wr(A_MON, 8'h00); rd(A_MON, 8'h12, "R3 month zero");
    wr(A_YEAR, 8'h99); rd(A_YEAR, 8'h99, "R3 year accept");
    wr(A_YEAR, 8'h9A); rd(A_YEAR, 8'h99, "R3 year reject");
  endtask

  task automatic t_ctrl_wday_gap;
    wr(A_CTRL, 8'h2F); rd(A_CTRL, 8'h9F, "R5");
    wr(A_CTRL, 8'h00); rd(A_CTRL, 8'h90, "R5");
    wr(A_WDAY, 8'hFD); rd(A_WDAY, 8'h45, "R6");
    wr(A_SEC, 8'h12);
    wr(A_GAP, 8'hFF); rd(A_GAP, 8'h00, "R7 gap");
    wr(13'h0001, 8'h33); rd(13'h0001, 8'h00, "R7 outside");
    rd(A_SEC, 8'h12, "R7 no effect");
  endtask

  task automatic t_halt;
    wr(A_SEC, 8'h90); rd(A_SEC, 8'h90, "R4 flag");
    pulse; pulse; rd(A_SEC, 8'h90, "R4 frozen");
    wr(A_SEC, 8'hE5); rd(A_SEC, 8'h90, "R4 flag kept, value rejected");
    wr(A_SEC, 8'h10); pulse; rd(A_SEC, 8'h11, "R4 resume");
  endtask

  task automatic t_rollover;
    set_all(8'h23, 8'h05, 8'h15, 8'h23, 8'h59, 8'h59); wr(A_WDAY, 8'h06);
    pulse;
    rd(A_SEC, 8'h00, "R8"); rd(A_MIN, 8'h00, "R8"); rd(A_HOUR, 8'h00, "R8");
    rd(A_DATE, 8'h16, "R8"); rd(A_WDAY, 8'h00, "R8 weekday");
    rd(A_MON, 8'h05, "R8");
  endtask

  task automatic t_month_len;
    set_all(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); pulse;
    rd(A_DATE, 8'h01, "R9 feb"); rd(A_MON, 8'h03, "R9 feb");
    set_all(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); pulse;
    rd(A_DATE, 8'h29, "R9 leap");
    wr(A_HOUR, 8'h23); wr(A_MIN, 8'h59); wr(A_SEC, 8'h59); pulse;
    rd(A_DATE, 8'h01, "R9 leap end"); rd(A_MON, 8'h03, "R9 leap end");
    set_all(8'h24, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59); pulse;
    rd(A_DATE, 8'h01, "R9 april"); rd(A_MON, 8'h05, "R9 april");
  endtask

  task automatic t_year;
    set_all(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59); pulse;
    rd(A_YEAR, 8'h00, "R10"); rd(A_MON, 8'h01, "R10"); rd(A_DATE, 8'h01, "R10");
  endtask

  task automatic t_collide;
    wr(A_HOUR, 8'h05); wr(A_MIN, 8'h10); wr(A_SEC, 8'h59);
    @(negedge clk); addr = A_SEC; wdata = 8'h30; wr_en = 1'b1; tick = 1'b1;
    #1; checks++;
    if (rdata !== 8'h59) begin
      errors++; $display("FAIL R11 comb read actual=%h expected=59", rdata);
    end
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    rd(A_SEC, 8'h30, "R11 write wins"); rd(A_MIN, 8'h11, "R11 carry");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_sec_min_range;
    t_other_range;
    t_ctrl_wday_gap;
    t_halt;
    t_rollover;
    t_month_len;
    t_year;
    t_collide;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule